// File: doc/BRIEF.md
# Programmable interrupt router

This block collects up to 32 interrupt request wires and forwards them to a small grid of processor interrupt lines: four cores, each with four parent lines. Every request wire is first brought into the block's clock domain, then judged by its own trigger setting (high level, low level, rising edge or falling edge), gated by a per-source enable, and finally steered by a byte-wide route entry to any set of cores and lines. The sixteen outputs are the OR of every enabled, active source routed to them.

Software reaches the block through a plain 32-bit register port with byte enables. Route entries live in the first 32 byte addresses, one per source, so a single source can be re-steered with a one-byte write. Enables are changed through a set register and a clear register, so no read-modify-write is needed, and a status word shows the enable state. Edge-detected requests hold a sticky flag until software acknowledges them by writing a one into the pending word.

Top module: `irq_router`

## Requirements
- R1: After reset every enable, polarity, edge and route bit reads 0, the pending word at 0x40 reads 0 and all outputs are low.
- R2: The route entry of source n is the byte at address n (0x00 to 0x1F); bits [7:4] choose parent lines 0..3 and bits [3:0] choose cores 0..3. Only the byte lanes whose byte enable is 1 are written.
- R3: Writing 0x28 sets the enable of every source whose data bit is 1; data bits of 0 leave enables unchanged. The enable state reads back at 0x24.
- R4: Writing 0x2C clears the enable of every source whose data bit is 1; data bits of 0 leave enables unchanged.
- R5: With edge bit 0 and polarity bit 0 (register 0x34 and 0x30), a source is active while its input is high. A change on the input reaches the outputs on the second rising clock edge after it, through a two-flop synchronizer.
- R6: With edge bit 0 and polarity bit 1 a source is active while its input is low.
- R7: With edge bit 1 and polarity bit 0 a rising input sets a sticky flag that stays set after the input falls, until a write to 0x40 with a 1 in that source's bit.
- R8: With edge bit 1 and polarity bit 1 only a falling input sets the sticky flag; a rising input does not.
- R9: Bit n of the pending word 0x40 is 1 only when source n is enabled and active. Edge flags are captured while a source is disabled and appear once it is enabled.
- R10: Output irq_out[c*4+k] is high when any enabled, active source has line bit k and core bit c set in its route entry. A route byte with several bits drives every chosen output; a route byte with a zero nibble drives none.
- R11: Reads of unmapped or misaligned addresses (including 0x38) return 0; writes to them, and to the read-only words 0x24 and 0x40 apart from flag clearing, change no state.
- R12: When an edge is detected in the same cycle as a clear write for that source, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request wires, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1 |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 16 | Parent lines, index core*4+line |

## Verification
The delicate coincidence is an edge being detected on a source in the very cycle that software writes a one to acknowledge that source's flag. The bench times an input rise so that the synchronized edge lands on the clock edge that also carries the clear write to 0x40, then reads the pending word and expects the flag still set; a second clear must then drop it, showing the clear path itself works.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   // word indices (byte address >> 2) of the control words
   localparam logic [5:0] WI_EN_STAT = 6'h09;
   localparam logic [5:0] WI_EN_SET  = 6'h0A;
   localparam logic [5:0] WI_EN_CLR  = 6'h0B;
   localparam logic [5:0] WI_POL     = 6'h0C;
   localparam logic [5:0] WI_EDGE    = 6'h0D;
   localparam logic [5:0] WI_PEND    = 6'h10;

   // trigger code formed as {edge, polarity}
   typedef enum logic [1:0] {
      TRIG_LVL_HI = 2'b00,
      TRIG_LVL_LO = 2'b01,
      TRIG_RISE   = 2'b10,
      TRIG_FALL   = 2'b11
   } trig_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
   import irq_router_pkg::*;
#(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] pol,
   input  logic [N-1:0] edg,
   input  logic [N-1:0] clr,
   output logic [N-1:0] hit
);
   for (genvar i = 0; i < N; i++) begin : g_src
      trig_t mode;
      logic  prev_q, flag_q, det, hit_b;

      assign mode = trig_t'({edg[i], pol[i]});

      always_comb begin
         det   = 1'b0;
         hit_b = 1'b0;
         case (mode)
            TRIG_LVL_HI: hit_b = lvl[i];
            TRIG_LVL_LO: hit_b = ~lvl[i];
            TRIG_RISE: begin
               det   = lvl[i] & ~prev_q;
               hit_b = flag_q;
            end
            TRIG_FALL: begin
               det   = ~lvl[i] & prev_q;
               hit_b = flag_q;
            end
            default: ;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
         end else begin
            prev_q <= lvl[i];
            // a fresh edge outranks an acknowledge in the same cycle
            flag_q <= det | (flag_q & ~clr[i] & edg[i]);
         end
      end

      assign hit[i] = hit_b;

      // R7: a latched flag survives until acknowledged
      p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q && edg[i] && !clr[i]) |=> flag_q);

      // R8: a flag is only born from a level change in edge mode
      p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_q) |-> $past(edg[i] && (lvl[i] != prev_q)));

      // R12: detection wins over a simultaneous acknowledge
      p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (det && clr[i]) |=> flag_q);
   end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int N_SRC  = 32,
   parameter int N_CORE = 4,
   parameter int N_LINE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         act,
   input  logic [N_SRC-1:0][7:0]    route,
   output logic [N_CORE*N_LINE-1:0] irq
);
   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      for (genvar k = 0; k < N_LINE; k++) begin : g_line
         logic [N_SRC-1:0] pick;
         for (genvar i = 0; i < N_SRC; i++) begin : g_pick
            assign pick[i] = route[i][4+k] & route[i][c];
         end
         assign irq[c*N_LINE+k] = |(act & pick);
      end
   end

   // R10: with nothing active, no line is driven
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |-> (irq == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int N_SRC       = 32,
   parameter int N_CORE      = 4,
   parameter int N_LINE      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_SRC-1:0]         irq_in,
   input  logic                     bus_sel,
   input  logic                     bus_we,
   input  logic [7:0]               bus_addr,
   input  logic [3:0]               bus_be,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic [N_CORE*N_LINE-1:0] irq_out
);
   localparam int ROUTE_WORDS = N_SRC / 4;

   if (N_SRC < 4 || N_SRC > 32 || (N_SRC % 4) != 0) begin : g_bad_src
      $error("irq_router: N_SRC must be a multiple of 4 from 4 to 32");
   end
   if (N_CORE < 1 || N_CORE > 4 || N_LINE < 1 || N_LINE > 4) begin : g_bad_fan
      $error("irq_router: core and line counts must be 1..4");
   end

   logic [N_SRC-1:0][7:0] route_q;
   logic [N_SRC-1:0]      en_q, pol_q, edge_q;
   logic [N_SRC-1:0]      lvl_s, hit, act, ack;
   logic [31:0]           lane_mask;
   logic [N_SRC-1:0]      wbits, wmask;
   logic [5:0]            widx;
   logic                  aligned, wr, is_route;

   assign widx      = bus_addr[7:2];
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign wr        = bus_sel & bus_we & aligned;
   assign is_route  = (widx < 6'(ROUTE_WORDS));
   assign lane_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
   assign wmask     = lane_mask[N_SRC-1:0];
   assign wbits     = bus_wdata[N_SRC-1:0] & wmask;
   assign ack       = (wr && widx == WI_PEND) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         en_q    <= '0;
         pol_q   <= '0;
         edge_q  <= '0;
      end else if (wr) begin
         for (int i = 0; i < N_SRC; i++) begin
            if (widx == 6'(i / 4) && bus_be[i % 4])
               route_q[i] <= bus_wdata[8*(i%4) +: 8];
         end
         case (widx)
            WI_EN_SET: en_q   <= en_q | wbits;
            WI_EN_CLR: en_q   <= en_q & ~wbits;
            WI_POL:    pol_q  <= (pol_q & ~wmask) | wbits;
            WI_EDGE:   edge_q <= (edge_q & ~wmask) | wbits;
            default: ;
         endcase
      end
   end

   irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl_s)
   );

   irq_trigger #(.N(N_SRC)) u_trig (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(pol_q), .edg(edge_q),
      .clr(ack), .hit(hit)
   );

   assign act = hit & en_q;

   irq_route #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_route (
      .clk(clk), .rst_n(rst_n), .act(act), .route(route_q), .irq(irq_out)
   );

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (is_route) begin
            for (int b = 0; b < 4; b++)
               bus_rdata[8*b +: 8] = route_q[int'(widx)*4 + b];
         end else begin
            case (widx)
               WI_EN_STAT: bus_rdata[N_SRC-1:0] = en_q;
               WI_POL:     bus_rdata[N_SRC-1:0] = pol_q;
               WI_EDGE:    bus_rdata[N_SRC-1:0] = edge_q;
               WI_PEND:    bus_rdata[N_SRC-1:0] = act;
               default: ;
            endcase
         end
      end
   end

   logic unmapped;
   assign unmapped = !aligned || (!is_route && widx != WI_EN_SET && widx != WI_EN_CLR
                     && widx != WI_POL && widx != WI_EDGE);

   // R3: every written one lands in the enable state
   p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && widx == WI_EN_SET && bus_be == 4'hF)
      |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

   // R4: every written one is removed from the enable state
   p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && widx == WI_EN_CLR && bus_be == 4'hF)
      |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

   // R11: writes outside the control map leave the settings alone
   p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && unmapped)
      |=> ($stable(en_q) && $stable(pol_q) && $stable(edge_q) && $stable(route_q)));
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_out;

   int total = 0, bad = 0;
   bit done = 0;

   typedef struct {
      bit          is_out;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t q[$];

   always #4 clk = ~clk;

   irq_router u_irq_router (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   // monitor: one expected item per falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_out ? {16'h0, irq_out} : bus_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push_out(input logic [15:0] e, input string tag);
      item_t it;
      it.is_out = 1'b1; it.exp = {16'h0, e}; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic chk_out(input logic [15:0] e, input string tag);
      @(posedge clk); #1;
      push_out(e, tag);
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_addr = a;
      it.is_out = 1'b0; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic set_in(input logic [31:0] v);
      @(posedge clk); #1;
      irq_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk_rd(8'h24, 32'h0, "R1 enables");
      chk_rd(8'h30, 32'h0, "R1 polarity");
      chk_rd(8'h34, 32'h0, "R1 edge");
      chk_rd(8'h00, 32'h0, "R1 route");
      chk_rd(8'h40, 32'h0, "R1 pending");
      chk_out(16'h0, "R1 outputs");

      // R2 single byte lane then full word
      wr(8'h04, 32'hAABBCCDD, 4'b0010);
      chk_rd(8'h04, 32'h0000CC00, "R2 byte lane");
      wr(8'h00, 32'hC3002211, 4'hF);
      chk_rd(8'h00, 32'hC3002211, "R2 word");

      // R3 / R4 enable set and clear
      wr(8'h28, 32'h0000000F, 4'hF);
      chk_rd(8'h24, 32'h0000000F, "R3 set");
      wr(8'h28, 32'h00000010, 4'hF);
      chk_rd(8'h24, 32'h0000001F, "R3 zeros keep");
      wr(8'h2C, 32'h00000014, 4'hF);
      chk_rd(8'h24, 32'h0000000B, "R4 clear");
      wr(8'h28, 32'h0000000F, 4'hF);
      chk_rd(8'h24, 32'h0000000F, "R4 reenable");

      // R5 level high with synchronizer latency
      set_in(32'h1);
      push_out(16'h0000, "R5 latency 0 edges");
      chk_out(16'h0000, "R5 latency 1 edge");
      chk_out(16'h0001, "R5 latency 2 edges");
      chk_rd(8'h40, 32'h1, "R5 pending");
      set_in(32'h0);
      idle(3);
      chk_out(16'h0000, "R5 release");

      // R6 active low
      wr(8'h30, 32'h2, 4'hF);
      chk_rd(8'h40, 32'h2, "R6 low pending");
      chk_out(16'h0020, "R6 core1 line1");
      set_in(32'h2);
      idle(3);
      chk_rd(8'h40, 32'h0, "R6 high idle");

      // R10 multi-target and empty route
      set_in(32'hE);
      idle(3);
      chk_rd(8'h40, 32'hC, "R10 pending");
      chk_out(16'h00CC, "R10 fan-out");
      set_in(32'h2);
      idle(3);
      chk_out(16'h0000, "R10 released");

      // R7 rising edge sticky
      wr(8'h34, 32'h1, 4'hF);
      set_in(32'h3);
      idle(4);
      chk_rd(8'h40, 32'h1, "R7 rise latched");
      chk_out(16'h0001, "R7 output");
      set_in(32'h2);
      idle(4);
      chk_rd(8'h40, 32'h1, "R7 held after fall");
      wr(8'h40, 32'h1, 4'hF);
      chk_rd(8'h40, 32'h0, "R7 acknowledged");
      chk_out(16'h0000, "R7 output cleared");

      // R8 falling edge
      wr(8'h30, 32'h3, 4'hF);
      set_in(32'h3);
      idle(4);
      chk_rd(8'h40, 32'h0, "R8 rise ignored");
      set_in(32'h2);
      idle(4);
      chk_rd(8'h40, 32'h1, "R8 fall latched");
      wr(8'h40, 32'h1, 4'hF);
      chk_rd(8'h40, 32'h0, "R8 acknowledged");

      // R9 capture while disabled
      wr(8'h2C, 32'h1, 4'hF);
      set_in(32'h3);
      idle(4);
      set_in(32'h2);
      idle(4);
      chk_rd(8'h40, 32'h0, "R9 masked pending");
      chk_out(16'h0000, "R9 masked output");
      wr(8'h28, 32'h1, 4'hF);
      chk_rd(8'h40, 32'h1, "R9 appears on enable");
      chk_out(16'h0001, "R9 output on enable");
      wr(8'h40, 32'h1, 4'hF);
      chk_rd(8'h40, 32'h0, "R9 acknowledged");

      // R12 edge and acknowledge in the same cycle
      wr(8'h30, 32'h2, 4'hF);
      @(posedge clk); #1;
      irq_in = 32'h3;
      @(posedge clk); #1;
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h1; bus_be = 4'hF;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
      chk_rd(8'h40, 32'h1, "R12 set wins");
      wr(8'h40, 32'h1, 4'hF);
      chk_rd(8'h40, 32'h0, "R12 later clear");

      // R11 unmapped and read-only words
      wr(8'h38, 32'hFFFFFFFF, 4'hF);
      wr(8'h24, 32'hFFFFFFFF, 4'hF);
      wr(8'h2A, 32'hFFFFFFFF, 4'hF);
      chk_rd(8'h38, 32'h0, "R11 unmapped read");
      chk_rd(8'h24, 32'h0000000F, "R11 enables kept");
      chk_rd(8'h34, 32'h1, "R11 edge kept");
      chk_rd(8'h01, 32'h0, "R11 misaligned read");

      idle(2);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule